// File: doc/BRIEF.md
# Serial-Controlled Video Parameter Register Bank

This block is a two-wire serial slave that holds sixteen byte-wide registers. Each register has a subaddress and carries a picture parameter or a control setting. A host addresses the device, sends a subaddress and then one or more data bytes. It can also read back one status byte. The status byte carries a sticky supply-low flag and three 2-bit white-level comparison results, one each for the red, green and blue channels. Reading the status byte clears the three comparison results.

The live register contents are presented in parallel on `regs_o`, with register n at bits [8n+7:8n]. Writes can land at once, or they can be deferred. In deferred mode the received byte waits in a single shadow slot and reaches the live register on the next vertical-blanking strobe. While a byte waits, the block refuses further data.

The serial data stream uses a valid/ready handshake inside the block. A received subaddress byte or data byte is offered on `rx_valid`. The register file either takes it (ready high) or refuses it (ready low). A refused byte is never acknowledged, and the slave ignores the bus until the next START. The measurement inputs carry no ready signal, because they are accepted in every cycle.

Top module: `vctl_regbank`

## Requirements
- R1: After reset every live register reads 00h and the status byte reads 80h.
- R2: The bus address byte 88h (write) or 89h (read) is acknowledged by pulling SDA low during the ninth clock. Any other address byte gets no acknowledge and leaves the registers unchanged. The slave changes SDA only while SCL is low.
- R3: A transfer of address, subaddress and one data byte writes that byte to the addressed register, and each of the three bytes is acknowledged.
- R4: When bit 5 of register 0Ch is 0, further data bytes in the same transfer go to successive subaddresses, and the subaddress wraps from 0Fh to 00h.
- R5: Registers 00h to 0Ah keep only data bits 5..0, and their bits 7..6 always read 0.
- R6: Writes to subaddresses 0Bh, 0Eh and 0Fh are acknowledged but do not change any register.
- R7: A subaddress byte above 0Fh gets no acknowledge, and the data that follows changes no register.
- R8: When bit 5 of register 0Ch is 1, an accepted data byte leaves the live registers unchanged. The byte is applied in the cycle after the first clock edge at which `vblank_i` is high.
- R9: While a deferred byte is waiting, every data byte gets no acknowledge. In deferred mode only the first data byte of a transfer is accepted.
- R10: The status byte is laid out as bit 7 = supply-low flag, bits 6..5 = blue code, bits 4..3 = green code, bits 2..1 = red code, bit 0 = 0. A channel's code is loaded from `meas_code_i` (red [1:0], green [3:2], blue [5:4]) in a cycle where its `meas_valid_i` bit (red 0, green 1, blue 2) is high.
- R11: A status read sets every 2-bit code to 00. It also clears the supply-low flag unless the synchronized supply-low input is still high.
- R12: A rising edge of the synchronized `supply_low_i` sets every live register to 00h, discards a waiting deferred byte and sets the supply-low flag. This happens even when a commit falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| vblank_i | input | 1 | Vertical-blanking strobe that commits a deferred byte |
| supply_low_i | input | 1 | Supply-low indication, asynchronous |
| meas_valid_i | input | 3 | Per-channel new-measurement strobe (R, G, B) |
| meas_code_i | input | 6 | Per-channel 2-bit white-level result |
| regs_o | output | 128 | Live registers, register n at [8n+7:8n] |

## Verification
Two events can land on the same clock edge: the commit of a deferred byte triggered by `vblank_i`, and the clear caused by a rising supply-low edge. The bench first parks a byte in the shadow slot. It then raises `supply_low_i` and times a one-cycle `vblank_i` pulse so that both take effect at the same edge, which is three edges after the supply input changes because of the two-stage synchronizer. The result is judged at the ports. All registers must read zero. A later strobe must not bring back the discarded byte. The next write must be accepted and must land immediately.

// File: rtl/vctl_pkg.sv
package vctl_pkg;
  localparam int NREG = 16;
  localparam int DW = 8;
  localparam int AW = $clog2(NREG);
  localparam logic [6:0] DEV_ADDR = 7'h44;
  localparam int BUF_REG = 12;
  localparam int BUF_BIT = 5;
  localparam int NARROW_LAST = 10;
  localparam int NARROW_W = 6;
  localparam logic [NREG-1:0] RSVD_MASK = 16'hC800;
  localparam int NCH = 3;
  localparam int CODE_W = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {BUS_IDLE, BUS_RX, BUS_ACK, BUS_TX} bus_st_e;
  typedef enum logic [1:0] {PH_DEV, PH_SUB, PH_DATA} phase_e;
endpackage

// File: rtl/vctl_sync.sv
module vctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= INIT;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vctl_i2c_slave.sv
module vctl_i2c_slave
  import vctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  output logic          sda_oe,
  output logic          rx_valid,
  output logic          rx_sub,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  output logic          rd_take,
  input  logic [DW-1:0] rd_data
);
  logic          scl_q, sda_q;
  bus_st_e       st;
  phase_e        ph;
  logic [3:0]    cnt;
  logic [DW-1:0] sr;
  logic          rw;
  logic          start_c, stop_c, rise, fall, byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_c   = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  assign rise      = scl_s & ~scl_q;
  assign fall      = ~scl_s & scl_q;
  assign byte_done = (st == BUS_RX) && (cnt == 4'd8) && fall;

  assign rx_valid = byte_done && (ph != PH_DEV);
  assign rx_sub   = (ph == PH_SUB);
  assign rx_data  = sr;
  assign rd_take  = (st == BUS_ACK) && fall && rw && (ph == PH_DEV);
  assign sda_oe   = (st == BUS_ACK) || ((st == BUS_TX) && !sr[DW-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BUS_IDLE;
      ph  <= PH_DEV;
      cnt <= '0;
      sr  <= '0;
      rw  <= 1'b0;
    end else if (start_c) begin
      st  <= BUS_RX;
      ph  <= PH_DEV;
      cnt <= '0;
      rw  <= 1'b0;
    end else if (stop_c) begin
      st <= BUS_IDLE;
    end else begin
      case (st)
        BUS_RX: begin
          if (rise && cnt != 4'd8) begin
            sr  <= {sr[DW-2:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (ph == PH_DEV) begin
              if (sr[DW-1:1] == DEV_ADDR) begin
                st <= BUS_ACK;
                rw <= sr[0];
              end else begin
                st <= BUS_IDLE;
              end
            end else begin
              st <= rx_ready ? BUS_ACK : BUS_IDLE;
            end
          end
        end
        BUS_ACK: begin
          if (fall) begin
            cnt <= '0;
            if (rd_take) begin
              st <= BUS_TX;
              sr <= rd_data;
            end else begin
              st <= BUS_RX;
              ph <= (ph == PH_DEV) ? PH_SUB : PH_DATA;
            end
          end
        end
        BUS_TX: begin
          if (fall) begin
            if (cnt == 4'd7) st <= BUS_IDLE;
            else begin
              sr  <= {sr[DW-2:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R2
  AST_ACK_AFTER_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BUS_ACK) |-> (cnt == 4'd8)); // R2
endmodule

// File: rtl/vctl_regfile.sv
module vctl_regfile
  import vctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic                  rx_sub,
  input  logic [DW-1:0]         rx_data,
  output logic                  rx_ready,
  input  logic                  rd_take,
  output logic [DW-1:0]         rd_data,
  input  logic                  vblank_i,
  input  logic                  supply_low_s,
  input  logic [NCH-1:0]        meas_valid_i,
  input  logic [NCH*CODE_W-1:0] meas_code_i,
  output logic [NREG*DW-1:0]    regs_o
);
  localparam logic [DW-1:0] NARROW_MASK = DW'((1 << NARROW_W) - 1);

  logic [DW-1:0]         live [NREG];
  logic [DW-1:0]         shadow_val;
  logic [AW-1:0]         shadow_idx, sub_ptr;
  logic                  pend, first_data, supply_q, por_flag;
  logic [NCH*CODE_W-1:0] codes;
  logic                  buf_en, por_rise, sub_ok, data_ok, wr_fire, wr_eff, commit;
  logic [DW-1:0]         wr_val;

  assign buf_en   = live[BUF_REG][BUF_BIT];
  assign por_rise = supply_low_s & ~supply_q;
  assign sub_ok   = (rx_data < DW'(NREG));
  assign data_ok  = !pend && (!buf_en || first_data);
  assign rx_ready = rx_sub ? sub_ok : data_ok;
  assign wr_fire  = rx_valid && !rx_sub && rx_ready;
  assign wr_eff   = wr_fire && !RSVD_MASK[sub_ptr];
  assign commit   = vblank_i && pend;
  assign wr_val   = (sub_ptr <= AW'(NARROW_LAST)) ? (rx_data & NARROW_MASK) : rx_data;
  assign rd_data  = {por_flag, codes, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) live[i] <= '0;
      shadow_val <= '0;
      shadow_idx <= '0;
      sub_ptr    <= '0;
      pend       <= 1'b0;
      first_data <= 1'b0;
      supply_q   <= 1'b0;
      por_flag   <= 1'b1;
      codes      <= '0;
    end else begin
      supply_q <= supply_low_s;
      if (por_rise) begin
        for (int i = 0; i < NREG; i++) live[i] <= '0;
        pend <= 1'b0;
      end else begin
        if (commit) begin
          live[shadow_idx] <= shadow_val;
          pend <= 1'b0;
        end
        if (wr_eff) begin
          if (buf_en) begin
            shadow_idx <= sub_ptr;
            shadow_val <= wr_val;
            pend       <= 1'b1;
          end else begin
            live[sub_ptr] <= wr_val;
          end
        end
      end
      if (rx_valid && rx_sub && sub_ok) begin
        sub_ptr    <= rx_data[AW-1:0];
        first_data <= 1'b1;
      end else if (wr_fire) begin
        sub_ptr    <= sub_ptr + 1'b1;
        first_data <= 1'b0;
      end
      for (int c = 0; c < NCH; c++) begin
        if (meas_valid_i[c]) codes[c*CODE_W +: CODE_W] <= meas_code_i[c*CODE_W +: CODE_W];
        else if (rd_take)    codes[c*CODE_W +: CODE_W] <= '0;
      end
      if (supply_low_s) por_flag <= 1'b1;
      else if (rd_take) por_flag <= 1'b0;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_out
    assign regs_o[i*DW +: DW] = live[i];
  end

  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !vblank_i && !por_rise) |=> $stable(regs_o)); // R8
  AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && RSVD_MASK[sub_ptr] && !commit && !por_rise) |=> $stable(regs_o)); // R6
  AST_SUPPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    por_rise |=> (regs_o == '0) && !pend); // R12
  AST_READ_CLEARS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && meas_valid_i == '0) |=> (rd_data[DW-2:1] == '0)); // R11
endmodule

// File: rtl/vctl_regbank.sv
module vctl_regbank
  import vctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  vblank_i,
  input  logic                  supply_low_i,
  input  logic [NCH-1:0]        meas_valid_i,
  input  logic [NCH*CODE_W-1:0] meas_code_i,
  output logic [NREG*DW-1:0]    regs_o
);
  logic          scl_s, sda_s, supply_s;
  logic          rx_valid, rx_sub, rx_ready, rd_take;
  logic [DW-1:0] rx_data, rd_data;

  vctl_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  vctl_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_pwr_sync (
    .clk(clk), .rst_n(rst_n), .d(supply_low_i), .q(supply_s)
  );

  vctl_i2c_slave u_slave (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_oe(sda_oe_o),
    .rx_valid(rx_valid), .rx_sub(rx_sub), .rx_data(rx_data), .rx_ready(rx_ready),
    .rd_take(rd_take), .rd_data(rd_data)
  );

  vctl_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sub(rx_sub), .rx_data(rx_data),
    .rx_ready(rx_ready), .rd_take(rd_take), .rd_data(rd_data), .vblank_i(vblank_i),
    .supply_low_s(supply_s), .meas_valid_i(meas_valid_i), .meas_code_i(meas_code_i),
    .regs_o(regs_o)
  );
endmodule

// File: tb/vctl_regbank_bench.sv
module vctl_regbank_bench;
  localparam int Q = 8;
  localparam logic [23:0] VEC [0:7] = '{
    24'h00FF3F,  // R5 narrow register drops bits 7..6
    24'h042222,  // R3
    24'h0AC505,  // R5
    24'h0C0707,  // R3 wide register, deferral bit clear
    24'h0DA5A5,  // R3
    24'h0B5500,  // R6
    24'h0E1200,  // R6
    24'h0FFF00   // R6
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl, sda_drv_low, vblank, supply_low, sda_oe, sda_line;
  logic [2:0] mv;
  logic [5:0] mc;
  logic [127:0] regs;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign sda_line = !(sda_oe || sda_drv_low);

  vctl_regbank u_vctl_regbank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .vblank_i(vblank), .supply_low_i(supply_low), .meas_valid_i(mv),
    .meas_code_i(mc), .regs_o(regs)
  );

  function automatic logic [7:0] rg(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv_low = 1'b0; scl = 1'b1; wq();
    sda_drv_low = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_drv_low = 1'b1; wq();
    scl = 1'b1; wq();
    sda_drv_low = 1'b0; wq(); wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv_low = !b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
    end
    sda_drv_low = 1'b0; wq();
    scl = 1'b1; wq();
    ack = !sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic rbyte(output logic [7:0] b);
    sda_drv_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq();
      b[i] = sda_line; wq();
      scl = 1'b0; wq();
    end
    wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic wr1(input logic [7:0] sub, input logic [7:0] d, output bit a0, output bit a1, output bit a2);
    i2c_start(); wbyte(8'h88, a0); wbyte(sub, a1); wbyte(d, a2); i2c_stop();
  endtask

  task automatic rd_status(output logic [7:0] b, output bit ack);
    i2c_start(); wbyte(8'h89, ack); rbyte(b); i2c_stop();
  endtask

  task automatic vb_pulse();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] st;
    rst_n = 1'b0; scl = 1'b1; sda_drv_low = 1'b0; vblank = 1'b0;
    supply_low = 1'b0; mv = '0; mc = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R1 registers after reset", regs[31:0] | regs[63:32] | regs[95:64] | regs[127:96], 0);
    rd_status(st, a0);
    check("R2 read address ack", a0, 1);
    check("R1 status after reset", st, 8'h80);
    rd_status(st, a0);
    check("R11 supply flag cleared by read", st, 8'h00);

    i2c_start(); wbyte(8'h90, a0); wbyte(8'h00, a1); i2c_stop();
    check("R2 foreign address refused", a0, 0);
    check("R2 foreign address no write", rg(0), 8'h00);

    for (int k = 0; k < 8; k++) begin
      wr1(VEC[k][23:16], VEC[k][15:8], a0, a1, a2);
      check("R3 vector acks", {a0, a1, a2}, 3'b111);
      check("R3 R5 R6 vector register value", rg(int'(VEC[k][23:16])), VEC[k][7:0]);
    end

    i2c_start(); wbyte(8'h88, a0); wbyte(8'h0E, a1);
    wbyte(8'h11, a2); wbyte(8'h22, a3); wbyte(8'h33, a0); i2c_stop();
    check("R4 burst acks", {a1, a2, a3, a0}, 4'b1111);
    check("R4 wrap to 00", rg(0), 8'h33);
    check("R6 burst reserved untouched", rg(14) | rg(15), 8'h00);
    i2c_start(); wbyte(8'h88, a0); wbyte(8'h01, a1);
    wbyte(8'h01, a2); wbyte(8'h02, a3); wbyte(8'h03, a0); i2c_stop();
    check("R4 burst sequence", {rg(1), rg(2), rg(3)}, 24'h010203);

    i2c_start(); wbyte(8'h88, a0); wbyte(8'h1A, a1); wbyte(8'h3F, a2); i2c_stop();
    check("R7 subaddress above range refused", {a1, a2}, 2'b00);
    check("R7 no register update", rg(10), 8'h05);

    wr1(8'h0C, 8'h20, a0, a1, a2);
    check("R8 deferral enable lands at once", rg(12), 8'h20);
    wr1(8'h02, 8'h15, a0, a1, a2);
    check("R8 deferred write acked", a2, 1);
    check("R8 live register held", rg(2), 8'h02);
    wr1(8'h04, 8'h30, a0, a1, a2);
    check("R9 data refused while pending", {a1, a2}, 2'b10);
    vb_pulse();
    check("R8 commit on blanking", rg(2), 8'h15);
    check("R9 refused byte not stored", rg(4), 8'h22);
    i2c_start(); wbyte(8'h88, a0); wbyte(8'h05, a1); wbyte(8'h10, a2); wbyte(8'h11, a3); i2c_stop();
    check("R9 single byte per deferred transfer", {a2, a3}, 2'b10);
    vb_pulse();
    check("R9 first byte committed", {rg(5), rg(6)}, 16'h1000);
    wr1(8'h0C, 8'h00, a0, a1, a2);
    check("R8 control write also deferred", rg(12), 8'h20);
    vb_pulse();
    check("R8 control commit", rg(12), 8'h00);

    @(negedge clk); mv = 3'b111; mc = 6'b01_11_10;
    @(negedge clk); mv = 3'b000;
    rd_status(st, a0);
    check("R10 status layout", st, 8'h3C);
    rd_status(st, a0);
    check("R11 codes cleared by read", st, 8'h00);

    wr1(8'h0C, 8'h20, a0, a1, a2);
    wr1(8'h01, 8'h2A, a0, a1, a2);
    check("R12 setup pending", rg(1), 8'h01);
    @(negedge clk); supply_low = 1'b1;
    @(negedge clk);
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 clear wins over commit", regs[63:0] | regs[127:64], 0);
    rd_status(st, a0);
    check("R12 supply flag set", st, 8'h80);
    supply_low = 1'b0;
    vb_pulse();
    check("R12 pending byte discarded", rg(1), 8'h00);
    wr1(8'h05, 8'h11, a0, a1, a2);
    check("R12 write accepted after clear", a2, 1);
    check("R12 immediate mode after clear", rg(5), 8'h11);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule